// File: doc/BRIEF.md
# Serial Converter Port Sequencer

This block is the digital control of a low-power 16-bit sampling converter that is read over a three-wire serial port. An active-low select and a serial clock come in from the pins and are brought into a fast system clock through synchronizers. Data leaves on a single serial line that has its own output enable, so a pad can put the line into high impedance. The converter core is not part of the block. A signed raw sample arrives on a parallel port and is captured when a conversion ends.

The block runs a fixed loop. A conversion phase lasts a set number of system clocks. A sleep phase then holds the result. An output phase shifts the result out, most significant bit first, one bit per serial clock falling edge. The output phase ends either on the sixteenth falling edge or when the select rises, and either event starts the next conversion. Outside the output phase the data line shows whether the converter is busy. A parameter selects two-wire operation, where the select is tied low and the sleep phase is skipped.

Top module: `adc_serial_sequencer`

## Requirements
- R1: After reset the block is converting. Its phases always run in the order conversion, sleep, output, then conversion again, and a sleep phase never returns directly to conversion.
- R2: A conversion lasts exactly CONV_CYCLES system clocks. The select and the serial clock cannot shorten it.
- R3: The sleep phase ends only in a cycle where the synchronized select and the synchronized serial clock are both low. The captured result does not change during sleep.
- R4: On entry to the output phase, sdo carries result bit 15 at once. Each later synchronized sck falling edge moves to the next lower bit, down to bit 0. Bits are plain unsigned binary.
- R5: The falling edge of sck that arrives while bit 0 is shown ends the output phase and starts a conversion.
- R6: A select rising edge during the output phase drops the bits that remain and starts a conversion, even when it falls in the same cycle as a clock falling edge.
- R7: sdo_oe is high exactly while the synchronized select is low. Both inputs reach the logic after SYNC_STAGES system clocks, and sdo is 0 whenever sdo_oe is low.
- R8: With sdo_oe high, sdo is 1 throughout a conversion and 0 throughout sleep.
- R9: With TWO_WIRE set, the end of a conversion leads straight to the output phase, which shows bit 15.
- R10: Serial clock edges during a conversion change neither its length nor the busy indication.
- R11: A raw sample above 65535 is captured as 65535, a negative sample is captured as 0, and any other sample is captured unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the highest sck rate |
| rst | input | 1 | Synchronous active-high power-on clear |
| cs_n_i | input | 1 | Active-low select from the pin, asynchronous |
| sck_i | input | 1 | Serial clock from the pin, asynchronous |
| sample_i | input | RAW_W (18) | Signed raw converter value, captured when a conversion ends |
| sdo | output | 1 | Serial data or busy flag, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for the sdo pad |

## Verification
Two events can meet in one cycle during the output phase: a select rising edge (an abort) and the sck falling edge on the last bit (normal completion). The bench provokes this by releasing select and dropping the clock on the same system clock edge after sixteen pulses. It then judges the result in three ways. Exactly one new conversion must follow, and its length must match the model. The busy flag must appear. A later read must return the next captured sample and nothing left over from the old shift. The reference model also sees mid-word aborts, where a clock edge and a select edge land close together, and compares both outputs on every cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_CONVERT = 2'd0,
    PH_SLEEP   = 2'd1,
    PH_OUTPUT  = 2'd2
  } phase_t;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] prev_o
);
  localparam int DEPTH = STAGES + 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [DEPTH-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[DEPTH-2:0], pin_i[b]};
    end
    assign level_o[b] = chain[STAGES-1];
    assign prev_o[b]  = chain[STAGES];
  end
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CYCLES = 16600
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] count;

  assign done = run && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) count <= '0;
    else if (!done)  count <= count + 1'b1;
  end
endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
  parameter int DATA_W = 16,
  parameter int RAW_W  = DATA_W + 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic signed [RAW_W-1:0]    raw_i,
  input  logic                       rewind,
  input  logic                       advance,
  output logic                       bit_o,
  output logic                       last_o,
  output logic [$clog2(DATA_W)-1:0]  idx_o,
  output logic [DATA_W-1:0]          word_o
);
  localparam int IW = $clog2(DATA_W);
  localparam logic signed [RAW_W-1:0] FULL = RAW_W'((64'd1 << DATA_W) - 1);

  function automatic logic [DATA_W-1:0] saturate(input logic signed [RAW_W-1:0] v);
    if (v < 0)         return '0;
    else if (v > FULL) return '1;
    else               return v[DATA_W-1:0];
  endfunction

  function automatic logic pick(input logic [DATA_W-1:0] w, input logic [IW-1:0] i);
    return w[(DATA_W - 1) - int'(i)];
  endfunction

  logic [DATA_W-1:0] word;
  logic [IW-1:0]     idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      idx  <= '0;
    end else begin
      if (load) word <= saturate(raw_i);
      if (load || rewind) idx <= '0;
      else if (advance)   idx <= idx + 1'b1;
    end
  end

  assign bit_o  = pick(word, idx);
  assign last_o = (idx == IW'(DATA_W - 1));
  assign idx_o  = idx;
  assign word_o = word;
endmodule

// File: rtl/adc_serial_sequencer.sv
module adc_serial_sequencer
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int RAW_W       = DATA_W + 2,
  parameter int CONV_CYCLES = 16600,
  parameter int SYNC_STAGES = 2,
  parameter bit TWO_WIRE    = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_n_i,
  input  logic                    sck_i,
  input  logic signed [RAW_W-1:0] sample_i,
  output logic                    sdo,
  output logic                    sdo_oe
);
  localparam int IW = $clog2(DATA_W);

  phase_t phase;
  phase_t after_convert;

  logic [1:0] pin_level, pin_prev;
  logic cs_lvl, sck_lvl, cs_rise, sck_fall;
  logic conv_done, enter_output, load, advance;
  logic cur_bit, last_bit, line_val;
  logic [IW-1:0]     bit_idx;
  logic [DATA_W-1:0] held_word;

  adc_seq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i({cs_n_i, sck_i}),
    .level_o(pin_level), .prev_o(pin_prev)
  );

  assign cs_lvl   = pin_level[1];
  assign sck_lvl  = pin_level[0];
  assign cs_rise  = pin_level[1] & ~pin_prev[1];
  assign sck_fall = pin_prev[0] & ~pin_level[0];

  adc_seq_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .run(phase == PH_CONVERT), .done(conv_done)
  );

  generate
    if (TWO_WIRE) begin : g_two_wire
      assign after_convert = PH_OUTPUT;
    end else begin : g_three_wire
      assign after_convert = PH_SLEEP;
    end
  endgenerate

  assign load         = (phase == PH_CONVERT) && conv_done;
  assign enter_output = (phase == PH_SLEEP) && !cs_lvl && !sck_lvl;
  assign advance      = (phase == PH_OUTPUT) && !cs_rise && sck_fall && !last_bit;

  adc_seq_shifter #(.DATA_W(DATA_W), .RAW_W(RAW_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .raw_i(sample_i),
    .rewind(enter_output), .advance(advance),
    .bit_o(cur_bit), .last_o(last_bit), .idx_o(bit_idx), .word_o(held_word)
  );

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_CONVERT;
    else begin
      unique case (phase)
        PH_CONVERT: if (conv_done) phase <= after_convert;
        PH_SLEEP:   if (enter_output) phase <= PH_OUTPUT;
        PH_OUTPUT:  if (cs_rise || (sck_fall && last_bit)) phase <= PH_CONVERT;
        default:    phase <= PH_CONVERT;
      endcase
    end
  end

  always_comb begin
    unique case (phase)
      PH_CONVERT: line_val = 1'b1;
      PH_SLEEP:   line_val = 1'b0;
      PH_OUTPUT:  line_val = cur_bit;
      default:    line_val = 1'b0;
    endcase
  end

  assign sdo_oe = ~cs_lvl;
  assign sdo    = sdo_oe & line_val;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input phase_t                    phase,
  input logic                      conv_done,
  input logic                      cs_lvl,
  input logic                      sck_lvl,
  input logic                      cs_rise,
  input logic                      sck_fall,
  input logic [$clog2(DATA_W)-1:0] bit_idx,
  input logic [DATA_W-1:0]         held_word,
  input logic                      sdo,
  input logic                      sdo_oe
);
  AST_CONVERT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CONVERT && !conv_done) |=> (phase == PH_CONVERT)); // R2
  AST_CONVERT_ENDS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CONVERT && conv_done) |=> (phase != PH_CONVERT)); // R2
  AST_SLEEP_NOT_BACK: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SLEEP) |=> (phase != PH_CONVERT)); // R1
  AST_OUTPUT_NOT_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OUTPUT) |=> (phase != PH_SLEEP)); // R1
  AST_SLEEP_WAITS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SLEEP && (cs_lvl || sck_lvl)) |=> (phase == PH_SLEEP)); // R3
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SLEEP) |=> $stable(held_word)); // R3
  AST_OUTPUT_FROM_MSB: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OUTPUT && $past(phase) != PH_OUTPUT) |-> (bit_idx == '0)); // R4
  AST_LAST_BIT_ENDS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OUTPUT && sck_fall && bit_idx == ($clog2(DATA_W))'(DATA_W - 1))
      |=> (phase == PH_CONVERT)); // R5
  AST_ABORT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OUTPUT && cs_rise) |=> (phase == PH_CONVERT)); // R6
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sdo); // R7
  AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CONVERT && sdo_oe) |-> sdo); // R8
  AST_READY_FLAG: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SLEEP && sdo_oe) |-> !sdo); // R8
endmodule

bind adc_serial_sequencer adc_seq_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .conv_done(conv_done),
  .cs_lvl(cs_lvl), .sck_lvl(sck_lvl), .cs_rise(cs_rise), .sck_fall(sck_fall),
  .bit_idx(bit_idx), .held_word(held_word), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/adc_serial_sequencer_test.sv
module adc_serial_sequencer_test;
  localparam int DW   = 16;
  localparam int RAW  = 18;
  localparam int CONV = 64;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck = 1'b1;
  logic signed [RAW-1:0] sample = 18'sd43981;
  logic sdo_a, oe_a, sdo_b, oe_b;
  logic finished = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  adc_serial_sequencer #(.DATA_W(DW), .RAW_W(RAW), .CONV_CYCLES(CONV), .TWO_WIRE(1'b0)) uut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck), .sample_i(sample),
    .sdo(sdo_a), .sdo_oe(oe_a)
  );

  adc_serial_sequencer #(.DATA_W(DW), .RAW_W(RAW), .CONV_CYCLES(CONV), .TWO_WIRE(1'b1)) uut2 (
    .clk(clk), .rst(rst), .cs_n_i(1'b0), .sck_i(sck), .sample_i(sample),
    .sdo(sdo_b), .sdo_oe(oe_b)
  );

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 = converting, 1 = sleeping, 2 = shifting out
  int m_ph[2], m_cnt[2], m_idx[2], m_res[2];
  int h_cs[2][3], h_sk[2][3];

  function automatic int clampv(input int v);
    if (v < 0) return 0;
    if (v > 65535) return 65535;
    return v;
  endfunction

  task automatic model_reset(input int m);
    m_ph[m] = 0; m_cnt[m] = 0; m_idx[m] = 0; m_res[m] = 0;
    for (int k = 0; k < 3; k++) begin h_cs[m][k] = 1; h_sk[m][k] = 1; end
  endtask

  task automatic model_step(input int m, input int cs_in, input int sk_in, input int raw, input int two);
    int csl = h_cs[m][1];
    int csp = h_cs[m][2];
    int skl = h_sk[m][1];
    int skp = h_sk[m][2];
    if (m_ph[m] == 0) begin
      if (m_cnt[m] == CONV - 1) begin
        m_res[m] = clampv(raw); m_idx[m] = 0; m_cnt[m] = 0;
        m_ph[m] = (two != 0) ? 2 : 1;
      end else m_cnt[m]++;
    end else if (m_ph[m] == 1) begin
      if (csl == 0 && skl == 0) begin m_ph[m] = 2; m_idx[m] = 0; end
    end else begin
      if (csl == 1 && csp == 0) m_ph[m] = 0;
      else if (skp == 1 && skl == 0) begin
        if (m_idx[m] == DW - 1) m_ph[m] = 0;
        else m_idx[m]++;
      end
    end
    h_cs[m][2] = h_cs[m][1]; h_cs[m][1] = h_cs[m][0]; h_cs[m][0] = cs_in;
    h_sk[m][2] = h_sk[m][1]; h_sk[m][1] = h_sk[m][0]; h_sk[m][0] = sk_in;
  endtask

  task automatic model_compare(input int m, input logic act_sdo, input logic act_oe);
    int e_oe = (h_cs[m][1] == 0) ? 1 : 0;
    int e_line;
    int e_sdo;
    string tag;
    if (m_ph[m] == 0) e_line = 1;
    else if (m_ph[m] == 1) e_line = 0;
    else e_line = (m_res[m] >> (DW - 1 - m_idx[m])) & 1;
    e_sdo = e_oe & e_line;
    if (m == 1) tag = "R9";
    else if (m_ph[m] == 0) tag = "R2";
    else if (m_ph[m] == 1) tag = "R3";
    else tag = "R4";
    check("R7", int'(act_oe) == e_oe, int'(act_oe), e_oe);
    check(tag, int'(act_sdo) == e_sdo, int'(act_sdo), e_sdo);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      model_reset(0); model_reset(1);
    end else begin
      model_step(0, int'(cs_n), int'(sck), int'(sample), 0);
      model_step(1, 0, int'(sck), int'(sample), 1);
      #2;
      model_compare(0, sdo_a, oe_a);
      model_compare(1, sdo_b, oe_b);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_hi(input int n, output logic [15:0] w);
    w = '0;
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; wait_cyc(HALF);
      w = {w[14:0], sdo_a};
      sck = 1'b1; wait_cyc(HALF);
    end
  endtask

  task automatic read_lo(output logic [15:0] w);
    w = '0;
    cs_n = 1'b0;
    for (int i = 0; i < 16; i++) begin
      wait_cyc(HALF);
      w = {w[14:0], sdo_a};
      sck = 1'b1; wait_cyc(HALF);
      sck = 1'b0;
    end
  endtask

  initial begin
    logic [15:0] w;
    wait_cyc(4);
    rst = 1'b0;

    // R1: busy immediately after reset
    wait_cyc(3);
    cs_n = 1'b0;
    wait_cyc(4);
    check("R1", oe_a == 1'b1 && sdo_a == 1'b1, int'(sdo_a), 1);
    wait_cyc(CONV);
    check("R8", sdo_a == 1'b0, int'(sdo_a), 0);
    check("R9", sdo_b == 1'b1, int'(sdo_b), 1);

    // R4: idle-high read of 0xABCD, then select release
    read_hi(16, w);
    check("R4", w == 16'hABCD, int'(w), 16'hABCD);
    cs_n = 1'b1; wait_cyc(4);
    sample = 18'sd70000;
    cs_n = 1'b0; wait_cyc(4);
    check("R6", sdo_a == 1'b1, int'(sdo_a), 1);

    // R10: clock pulses while converting are ignored
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; wait_cyc(HALF); sck = 1'b1; wait_cyc(HALF);
    end
    check("R10", sdo_a == 1'b1, int'(sdo_a), 1);
    wait_cyc(CONV);
    check("R8", sdo_a == 1'b0, int'(sdo_a), 0);

    // R11: saturation high, 17th pulse starts the next conversion
    read_hi(16, w);
    check("R11", w == 16'hFFFF, int'(w), 16'hFFFF);
    sample = -18'sd5;
    sck = 1'b0; wait_cyc(HALF); sck = 1'b1; wait_cyc(HALF);
    check("R5", sdo_a == 1'b1, int'(sdo_a), 1);

    // idle-low read: negative input saturates to zero, 16th fall restarts
    cs_n = 1'b1; sck = 1'b0;
    wait_cyc(CONV + 5);
    read_lo(w);
    check("R11", w == 16'h0000, int'(w), 0);
    sample = 18'sd58199;
    wait_cyc(4);
    sck = 1'b1; wait_cyc(4);
    check("R5", sdo_a == 1'b1, int'(sdo_a), 1);

    // R6: abort after three bits of 0xE357
    wait_cyc(CONV + 5);
    read_hi(3, w);
    check("R4", w[2:0] == 3'b111, int'(w[2:0]), 7);
    sample = 18'sd50085;
    cs_n = 1'b1; wait_cyc(4);
    cs_n = 1'b0; wait_cyc(4);
    check("R6", sdo_a == 1'b1, int'(sdo_a), 1);

    // collision: select rise on the same edge as the last falling clock
    wait_cyc(CONV + 5);
    read_hi(16, w);
    check("R4", w == 16'hC3A5, int'(w), 16'hC3A5);
    sample = 18'sd4660;
    @(negedge clk);
    sck = 1'b0; cs_n = 1'b1;
    wait_cyc(HALF);
    sck = 1'b1; cs_n = 1'b0;
    wait_cyc(4);
    check("R6", sdo_a == 1'b1, int'(sdo_a), 1);
    wait_cyc(CONV);
    check("R8", sdo_a == 1'b0, int'(sdo_a), 0);

    // R3: long sleep, no exit on one low input, result held
    sample = 18'sd777;
    wait_cyc(50);
    check("R3", sdo_a == 1'b0, int'(sdo_a), 0);
    cs_n = 1'b1; sck = 1'b0; wait_cyc(20);
    sck = 1'b1; wait_cyc(2);
    cs_n = 1'b0; wait_cyc(4);
    check("R3", sdo_a == 1'b0, int'(sdo_a), 0);
    read_hi(16, w);
    check("R3", w == 16'h1234, int'(w), 16'h1234);
    cs_n = 1'b1; wait_cyc(4);
    check("R7", oe_a == 1'b0 && sdo_a == 1'b0, int'(oe_a), 0);
    wait_cyc(10);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule